// File: doc/BRIEF.md
# Fractional-Rate PTP Time Counter

This block keeps a free-running time-of-day value for a network timestamping unit. The value has a 40-bit whole-nanosecond field with a 32-bit fractional-nanosecond accumulator below it. A tick fires every 8 ns, derived from the core clock by a fixed divider. On each tick the counter adds a fixed 8 ns step. It also applies a signed rate correction to the fractional accumulator. A carry out of the fraction lengthens that step to 9 ns, and a borrow shortens it to 7 ns. Software can therefore trim the clock frequency in steps of 2^-32 ns per tick.

Software reaches the counter through a small 32-bit register port, which has a one-cycle read latency. Reading the residue word freezes the nanosecond field into a snapshot, so the two following nanosecond reads are coherent. Writing the time is also staged. The low nanosecond word goes into a holding register, and the write of the high word loads both words at once and clears the fraction. A halt bit keeps the counter stopped from reset until software clears it. A rollover of the nanosecond field produces a one-cycle pulse and sets a sticky cause bit that drives an interrupt line.

Register word addresses: 0 residue (read only), 1 nanoseconds low, 2 nanoseconds high (bits 7:0), 3 rate, 4 control (bit 31 = halt), 5 cause (bit 0 = wrap, write 1 to clear).

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the residue, both nanosecond words, the rate and the cause word read 0, control reads 0x8000_0000 (halted), and `wrap_irq` is low.
- R2: With the rate at 0 and the counter running, the 72-bit value {ns, residue} grows by exactly 8·2^32 per tick, and a tick occurs every TICK_DIV core clocks (2 by default).
- R3: When rate bit 31 is 0, each tick adds rate[30:0] to the residue. When bit 31 is 1, each tick subtracts rate[30:0]. A carry adds 1 ns to the 8 ns step and a borrow removes 1 ns, so the 72-bit value grows by 8·2^32 ± rate[30:0] per tick. The rate word reads back as written.
- R4: A read of word 0 returns the current residue and captures the nanosecond field in the same cycle. Reads of words 1 and 2 return that capture until the next read of word 0.
- R5: A write to word 1 alone leaves the running time unchanged. A write to word 2 loads {word2[7:0], held word 1} as the nanosecond field and clears the residue to 0.
- R6: The counter advances only while control bit 31 is 0. While halted, the time holds its value and reads still return it.
- R7: When the nanosecond field rolls over past 2^40−1, `wrap_pulse` is high for one cycle, the cause bit and `wrap_irq` are set and stay set, and writing 1 to cause bit 0 clears them.
- R8: Read data appears on `reg_rdata` with `reg_rvalid` high in the clock cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (twice the tick rate by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe |
| wrap_pulse | output | 1 | One-cycle pulse on nanosecond rollover |
| wrap_irq | output | 1 | Sticky wrap interrupt |

## Verification
The counter is checked by differences rather than absolute values. Two coherent captures of {ns, residue} are taken a known, even number of clocks apart, and their difference is compared with the tick count times the per-tick increment. The rate patterns used are zero, a quarter nanosecond positive, a large negative value, and both extreme magnitudes. Zero rate separates the fixed step from the correction path. A single-signed small rate exposes carry handling, and the negative rates expose borrow and the sign decode. A preset near the top of the range shows whether rollover is modular and whether the pulse count and sticky cause bit are right. Halted windows and partial writes show whether anything moves the time when it should not.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_FRAC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_NS_LO = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_NS_HI = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_RATE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CAUSE = 3'd5;

  typedef struct packed {
    logic              carry;
    logic              borrow;
    logic [DATA_W-1:0] frac;
  } frac_step_t;

  // Sign-magnitude rate applied to the fractional accumulator.
  function automatic frac_step_t frac_advance(input logic [DATA_W-1:0] frac,
                                              input logic [DATA_W-1:0] rate);
    frac_step_t r;
    logic [DATA_W:0] mag;
    logic [DATA_W:0] acc;
    mag = {2'b00, rate[DATA_W-2:0]};
    if (rate[DATA_W-1]) acc = {1'b0, frac} - mag;
    else                acc = {1'b0, frac} + mag;
    r.frac   = acc[DATA_W-1:0];
    r.carry  = ~rate[DATA_W-1] & acc[DATA_W];
    r.borrow =  rate[DATA_W-1] & acc[DATA_W];
    return r;
  endfunction

endpackage

// File: rtl/ptp_tc_tick.sv
module ptp_tc_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cnt == CW'(DIV - 1))    cnt <= '0;
        else                             cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ptp_tc_core.sv
module ptp_tc_core
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_W     = 40,
  parameter int unsigned NOM_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic [DATA_W-1:0] rate,
  input  logic              load,
  input  logic [NS_W-1:0]   load_ns,
  output logic [NS_W-1:0]   ns,
  output logic [DATA_W-1:0] frac,
  output logic              wrap
);
  localparam logic [NS_W:0] NOM_EXT = (NS_W+1)'(NOM_STEP);

  frac_step_t    fs;
  logic          adv;
  logic [NS_W:0] step_ext;
  logic [NS_W:0] ns_sum;
  logic          wrap_now;

  always_comb begin
    fs       = frac_advance(frac, rate);
    adv      = tick & run & ~load;
    step_ext = NOM_EXT + {{NS_W{1'b0}}, fs.carry} - {{NS_W{1'b0}}, fs.borrow};
    ns_sum   = {1'b0, ns} + step_ext;
    wrap_now = adv & ns_sum[NS_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns   <= '0;
      frac <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= wrap_now;
      if (load) begin
        ns   <= load_ns;
        frac <= '0;
      end else if (adv) begin
        ns   <= ns_sum[NS_W-1:0];
        frac <= fs.frac;
      end
    end
  end

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ((ns - $past(ns)) >= NS_W'(NOM_STEP - 1)) &&
            ((ns - $past(ns)) <= NS_W'(NOM_STEP + 1)));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(ns) && $stable(frac));

  // R5
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ns == $past(load_ns)) && (frac == '0));

  // R7
  wrap_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (ns <= NS_W'(NOM_STEP)));
endmodule

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   ns,
  input  logic [DATA_W-1:0] frac,
  input  logic              wrap,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rate,
  output logic              run,
  output logic              load,
  output logic [NS_W-1:0]   load_ns,
  output logic              irq
);
  localparam int unsigned HI_W = NS_W - DATA_W;

  logic [DATA_W-1:0] lo_hold;
  logic [NS_W-1:0]   snap_ns;
  logic              halt;
  logic              cause;
  logic              snap_take;
  logic              cause_clr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    snap_take = rd_en & (addr == ADR_FRAC);
    cause_clr = wr_en & (addr == ADR_CAUSE) & wdata[0];
    load      = wr_en & (addr == ADR_NS_HI);
    load_ns   = {wdata[HI_W-1:0], lo_hold};
    run       = ~halt;
    irq       = cause;
    unique case (addr)
      ADR_FRAC:  rd_mux = frac;
      ADR_NS_LO: rd_mux = snap_ns[DATA_W-1:0];
      ADR_NS_HI: rd_mux = {{(DATA_W-HI_W){1'b0}}, snap_ns[NS_W-1:DATA_W]};
      ADR_RATE:  rd_mux = rate;
      ADR_CTRL:  rd_mux = {halt, {(DATA_W-1){1'b0}}};
      ADR_CAUSE: rd_mux = {{(DATA_W-1){1'b0}}, cause};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold  <= '0;
      snap_ns  <= '0;
      halt     <= 1'b1;
      cause    <= 1'b0;
      rate     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (snap_take) snap_ns <= ns;
      if (wr_en && addr == ADR_NS_LO) lo_hold <= wdata;
      if (wr_en && addr == ADR_RATE)  rate    <= wdata;
      if (wr_en && addr == ADR_CTRL)  halt    <= wdata[DATA_W-1];
      cause <= (cause & ~cause_clr) | wrap;
    end
  end

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(snap_ns));

  // R7
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause && !cause_clr) |=> cause);

  // R7
  cause_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause) |-> $past(wrap));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_W     = 40,
  parameter int unsigned NOM_STEP = 8,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        wrap_pulse,
  output logic        wrap_irq
);
  logic              tick;
  logic              run;
  logic              load;
  logic [NS_W-1:0]   load_ns;
  logic [NS_W-1:0]   ns;
  logic [DATA_W-1:0] frac;
  logic [DATA_W-1:0] rate;

  ptp_tc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ptp_tc_core #(.NS_W(NS_W), .NOM_STEP(NOM_STEP)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .rate(rate),
    .load(load), .load_ns(load_ns), .ns(ns), .frac(frac), .wrap(wrap_pulse)
  );

  ptp_tc_regs #(.NS_W(NS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .ns(ns), .frac(frac),
    .wrap(wrap_pulse), .rd_data(reg_rdata), .rd_valid(reg_rvalid),
    .rate(rate), .run(run), .load(load), .load_ns(load_ns), .irq(wrap_irq)
  );

  // R8
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
endmodule

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;
  localparam int TICK_DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        wrap_pulse;
  logic        wrap_irq;

  always #2 clk = ~clk;

  ptp_time_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .wrap_pulse(wrap_pulse), .wrap_irq(wrap_irq)
  );

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        mon_e;
  logic [31:0] last_rd;
  int          checks = 0;
  int          errors = 0;
  int          wrap_cnt = 0;
  bit          done = 1'b0;

  task automatic note(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item for every read response.
  always @(negedge clk) begin
    if (rst_n && wrap_pulse) wrap_cnt++;
    if (rst_n && reg_rvalid) begin
      last_rd = reg_rdata;
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected response actual=%h expected=none", reg_rdata);
      end else begin
        mon_e = sb_q.pop_front();
        if (mon_e.mask != 0) begin
          checks++;
          if ((reg_rdata & mon_e.mask) !== (mon_e.exp & mon_e.mask)) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", mon_e.tag, reg_rdata, mon_e.exp);
          end
        end
      end
    end
  end

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] e,
                        input logic [31:0] m, input string tag);
    exp_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    #1;
  endtask

  task automatic rd_raw(input logic [2:0] a, output logic [31:0] d);
    rd_exp(a, 32'h0, 32'h0, "");
    d = last_rd;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // Coherent capture of {ns[39:0], residue[31:0]}; spans 6 clocks.
  task automatic capture(output logic [71:0] t);
    logic [31:0] f, lo, hi;
    rd_raw(3'd0, f);
    rd_raw(3'd1, lo);
    rd_raw(3'd2, hi);
    t = {hi[7:0], lo, f};
  endtask

  function automatic logic [71:0] per_tick(input logic [31:0] rate);
    logic [71:0] inc;
    inc = 72'd8 << 32;
    if (rate[31]) inc = inc - {41'd0, rate[30:0]};
    else          inc = inc + {41'd0, rate[30:0]};
    return inc;
  endfunction

  // Capture, wait an even gap, capture again: 26 clocks = 13 ticks.
  task automatic rate_window(input logic [31:0] rate, input string tag,
                             output logic [71:0] b);
    logic [71:0] a;
    wr(3'd3, rate);
    rd_exp(3'd3, rate, 32'hFFFF_FFFF, "R3 rate readback");
    capture(a);
    repeat (20) @(negedge clk);
    capture(b);
    note(tag, b - a, per_tick(rate) * 72'((26) / TICK_DIV));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [71:0] t, a, b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    note("R1 irq low", {71'd0, wrap_irq}, 72'd0);
    rd_exp(3'd0, 32'h0, 32'hFFFF_FFFF, "R1 residue");
    rd_exp(3'd1, 32'h0, 32'hFFFF_FFFF, "R1 ns low");
    rd_exp(3'd2, 32'h0, 32'hFFFF_FFFF, "R1 ns high");
    rd_exp(3'd3, 32'h0, 32'hFFFF_FFFF, "R1 rate");
    rd_exp(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, "R1 control halted");
    rd_exp(3'd5, 32'h0, 32'hFFFF_FFFF, "R1 cause");

    // R6 halted from reset: no movement
    repeat (20) @(negedge clk);
    capture(t);
    note("R6 halted after reset", t, 72'd0);

    // R5 partial write has no effect, high word commits
    wr(3'd1, 32'h0000_1000);
    capture(t);
    note("R5 low word alone", t, 72'd0);
    wr(3'd2, 32'h0000_0012);
    capture(t);
    note("R5 commit on high word", t, {8'h12, 32'h0000_1000, 32'h0});

    // R6 start, R2 nominal step
    wr(3'd4, 32'h0);
    rd_exp(3'd4, 32'h0, 32'hFFFF_FFFF, "R6 control running");
    rate_window(32'h0, "R2 nominal 8 ns step", b);

    // R4 snapshot stays frozen until next residue read
    repeat (20) @(negedge clk);
    rd_exp(3'd1, b[63:32], 32'hFFFF_FFFF, "R4 frozen ns low");
    rd_exp(3'd2, {24'd0, b[71:64]}, 32'hFFFF_FFFF, "R4 frozen ns high");

    // R3 correction patterns
    rate_window(32'h4000_0000, "R3 positive quarter ns", b);
    rate_window(32'hE000_0000, "R3 negative large", b);
    rate_window(32'h7FFF_FFFF, "R3 positive max", b);
    rate_window(32'hFFFF_FFFF, "R3 negative max", b);

    // R6 halt mid-run: time frozen, still readable
    wr(3'd4, 32'h8000_0000);
    capture(a);
    repeat (20) @(negedge clk);
    capture(b);
    note("R6 frozen while halted", b, a);
    note("R6 reads return time", {71'd0, (a[71:32] != 40'd0)}, 72'd1);

    // R5 load clears residue; R7 rollover
    wr(3'd3, 32'h0);
    wr(3'd1, 32'hFFFF_FFD8);
    wr(3'd2, 32'h0000_00FF);
    capture(t);
    note("R5 load clears residue", t, {8'hFF, 32'hFFFF_FFD8, 32'h0});
    wrap_cnt = 0;
    wr(3'd4, 32'h0);
    capture(a);
    repeat (30) @(negedge clk);
    capture(b);
    note("R7 modular rollover", b - a, per_tick(32'h0) * 72'(36 / TICK_DIV));
    note("R7 one wrap pulse", 72'(wrap_cnt), 72'd1);
    note("R7 irq set", {71'd0, wrap_irq}, 72'd1);
    rd_exp(3'd5, 32'h1, 32'hFFFF_FFFF, "R7 cause set");
    repeat (10) @(negedge clk);
    note("R7 irq sticky", {71'd0, wrap_irq}, 72'd1);
    wr(3'd5, 32'h1);
    rd_exp(3'd5, 32'h0, 32'hFFFF_FFFF, "R7 cause cleared");
    note("R7 irq cleared", {71'd0, wrap_irq}, 72'd0);

    // R8 every read produced exactly one response
    note("R8 responses drained", 72'(sb_q.size()), 72'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule